// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block is the digital tail of a nine-stage pipelined analog-to-digital converter. Every conversion clock it receives a two-bit code from each of the nine quantizer stages. The stages work one clock apart, so on any given clock each stage is reporting on a different sample. The block delays every stage's code by the right number of clocks so that all nine codes for one sample meet. It then adds them with one bit of overlap between neighbouring stages. The redundant bit absorbs comparator offsets in the stages. The sum is clipped into a 10-bit straight offset binary word.

The corrected word is registered. It leaves the block exactly five clocks after the last stage code of its sample arrives. An active-low output enable and an active-high power-down control a per-bit drive enable, which stands in for the three-state pins. A data-valid flag marks words as trustworthy only once power-down has been low for long enough to refill the pipeline. Neither control ever stalls or clears the internal registers.

Top module: `adc_corr_backend`

## Requirements
- R1: `stageCodes` carries nine two-bit stage codes; stage k sits in bits [2k+1:2k], and stage 0 is the most significant. For a sample j, stage k's code is presented in clock cycle j+k, so stage 0 comes first and stage 8 comes last.
- R2: The nine codes belonging to one sample are combined with each other and never with codes of a neighbouring sample.
- R3: The corrected value is the sum over k of code_k × 2^(8−k). Adjacent stage codes therefore overlap by one bit position.
- R4: A sum above 1023 is saturated to 1023 (all ones).
- R5: Output coding is straight offset binary. 0 is negative full scale, 512 (stage 0 code 2, all other stages 0) is mid-scale, and 1023 is positive full scale.
- R6: A sample's word appears on `dataWord` five clock cycles after the cycle in which its stage-8 code was presented. It stays there for one cycle.
- R7: When `outEnN` is 1, every bit of `dataDrive` is 0. When both `outEnN` and `powerDown` are 0, every bit is 1. `outEnN` has no effect on `dataWord`.
- R8: While `powerDown` is 1, `dataDrive` is all zero and `dataValid` is 0. The pipeline keeps converting, so `dataWord` still follows R3 to R6.
- R9: `dataValid` is 1 only when the last five rising edges all saw `powerDown` at 0 and `powerDown` is 0 now. After power-down is released, the first five output words are flagged invalid.
- R10: While `rst` is 1, all pipeline registers clear, so `dataWord` is 0 and `dataValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| stageCodes | input | 18 | Nine skewed two-bit stage codes, stage k in bits [2k+1:2k] |
| outEnN | input | 1 | Output enable, active low |
| powerDown | input | 1 | Power-down request, active high |
| dataWord | output | 10 | Corrected straight offset binary word |
| dataDrive | output | 10 | Per-bit drive enable (0 means high impedance) |
| dataValid | output | 1 | Word is valid |

## Verification
All 1024 output values are first driven as non-redundant code sets, with stage 0 carrying the top two bits and the other stages one bit each. This sweep separates a wrong weight or a wrong stage delay, because each value has exactly one decomposition. A second stretch drives pseudo-random two-bit codes in every stage, so that carries ripple through the overlapping bits. An all-threes stretch then exercises the clipping at 1023. Output-enable windows, a ten-cycle power-down and a one-cycle power-down pulse run while samples keep flowing. These show that the controls change only the drive and the valid flag, and that the count of five invalid words restarts on every power-down.

// File: rtl/adcbe_pkg.sv
package adcbe_pkg;

  // Strobes handed from the control to the datapath output stage.
  typedef struct packed {
    logic driveOn;    // pins may be driven this cycle
    logic wordValid;  // current output word is trustworthy
  } adcbeStrobe_t;

endpackage

// File: rtl/adcbe_delay.sv
// Plain register chain of DEPTH cycles; DEPTH of zero is a wire.
module adcbe_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] taps [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else begin
          taps[0] <= d;
          for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
      end

      assign q = taps[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/adcbe_ctrl.sv
// Run-length counter for power-down recovery and drive gating.
module adcbe_ctrl
  import adcbe_pkg::*;
#(
  parameter int LATENCY = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         outEnN,
  input  logic         powerDown,
  output adcbeStrobe_t strb
);

  localparam int CNTW = $clog2(LATENCY + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(LATENCY);

  logic [CNTW-1:0] runCnt;

  // Counts edges seen with power-down low, saturating at the latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (powerDown) begin
      runCnt <= '0;
    end else if (runCnt != FULL) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  always_comb begin
    strb.driveOn   = !outEnN && !powerDown;
    strb.wordValid = (runCnt == FULL) && !powerDown;
  end

  // R9: any power-down restarts the invalid window.
  a_r9_pd_restart: assert property (@(posedge clk) disable iff (rst)
    powerDown |=> !strb.wordValid);

  // R9: a valid word never follows an edge that saw power-down.
  a_r9_valid_after_run: assert property (@(posedge clk) disable iff (rst)
    strb.wordValid |-> $past(!powerDown));

endmodule

// File: rtl/adcbe_datapath.sv
// Stage alignment, overlap addition, saturation and output pipeline.
module adcbe_datapath
  import adcbe_pkg::*;
#(
  parameter int NSTAGE  = 9,
  parameter int CODEW   = 2,
  parameter int LATENCY = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSTAGE*CODEW-1:0]   stageCodes,
  input  adcbeStrobe_t              strb,
  output logic [(NSTAGE-1)*(CODEW-1)+CODEW-1:0] dataWord,
  output logic [(NSTAGE-1)*(CODEW-1)+CODEW-1:0] dataDrive,
  output logic                      dataValid
);

  localparam int OUTW  = (NSTAGE-1)*(CODEW-1) + CODEW;
  localparam int SUMW  = OUTW + CODEW;
  localparam int PADD  = LATENCY - 3;   // capture, sum and output regs are fixed
  localparam logic [SUMW-1:0] MAXW = SUMW'((1 << OUTW) - 1);

  logic [CODEW-1:0] aligned [NSTAGE];
  logic [SUMW-1:0]  rawSum;
  logic [OUTW-1:0]  sumReg;
  logic [OUTW-1:0]  padOut;
  logic [OUTW-1:0]  outReg;

  // Earlier stages wait longer so every code meets the last stage's code.
  genvar k;
  generate
    for (k = 0; k < NSTAGE; k++) begin : g_align
      adcbe_delay #(.W(CODEW), .DEPTH(NSTAGE - k)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (stageCodes[k*CODEW +: CODEW]),
        .q   (aligned[k])
      );
    end
  endgenerate

  // Overlap addition: neighbouring stages share one bit position.
  always_comb begin
    rawSum = '0;
    for (int s = 0; s < NSTAGE; s++) begin
      rawSum = rawSum + (SUMW'(aligned[s]) << ((NSTAGE-1-s)*(CODEW-1)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sumReg <= '0;
    else if (rawSum > MAXW) sumReg <= '1;
    else sumReg <= rawSum[OUTW-1:0];
  end

  adcbe_delay #(.W(OUTW), .DEPTH(PADD)) u_pad (
    .clk (clk),
    .rst (rst),
    .d   (sumReg),
    .q   (padOut)
  );

  always_ff @(posedge clk) begin
    if (rst) outReg <= '0;
    else outReg <= padOut;
  end

  assign dataWord  = outReg;
  assign dataDrive = {OUTW{strb.driveOn}};
  assign dataValid = strb.wordValid;

  // R4: an overflowing sum is clipped to full scale.
  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (rawSum > MAXW) |=> (sumReg == {OUTW{1'b1}}));

  // R3: an in-range sum passes unchanged.
  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    (rawSum <= MAXW) |=> (SUMW'(sumReg) == $past(rawSum)));

endmodule

// File: rtl/adc_corr_backend.sv
module adc_corr_backend
  import adcbe_pkg::*;
#(
  parameter int NSTAGE  = 9,
  parameter int CODEW   = 2,
  parameter int LATENCY = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSTAGE*CODEW-1:0] stageCodes,
  input  logic                    outEnN,
  input  logic                    powerDown,
  output logic [(NSTAGE-1)*(CODEW-1)+CODEW-1:0] dataWord,
  output logic [(NSTAGE-1)*(CODEW-1)+CODEW-1:0] dataDrive,
  output logic                    dataValid
);

  adcbeStrobe_t strb;

  adcbe_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .outEnN    (outEnN),
    .powerDown (powerDown),
    .strb      (strb)
  );

  adcbe_datapath #(.NSTAGE(NSTAGE), .CODEW(CODEW), .LATENCY(LATENCY)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stageCodes (stageCodes),
    .strb       (strb),
    .dataWord   (dataWord),
    .dataDrive  (dataDrive),
    .dataValid  (dataValid)
  );

  // R7 and R8: either control parks every output bit.
  a_r7_hiz: assert property (@(posedge clk) disable iff (rst)
    (outEnN || powerDown) |-> (dataDrive == '0));

endmodule

// File: tb/adc_corr_backend_tb.sv
`timescale 1ns/1ps
module adc_corr_backend_tb;

  localparam int NCYC = 1450;

  logic        clk = 1'b0;
  logic        rst;
  logic [17:0] stageCodes;
  logic        outEnN;
  logic        powerDown;
  logic [9:0]  dataWord;
  logic [9:0]  dataDrive;
  logic        dataValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_corr_backend u_dut (
    .clk        (clk),
    .rst        (rst),
    .stageCodes (stageCodes),
    .outEnN     (outEnN),
    .powerDown  (powerDown),
    .dataWord   (dataWord),
    .dataDrive  (dataDrive),
    .dataValid  (dataValid)
  );

  // Stage code for sample j, stage k.
  function automatic int codeOf(int j, int k);
    if (j < 0) return 0;
    if (j < 1024) return (k == 0) ? (j >> 8) : ((j >> (8 - k)) & 1);
    if (j >= 1280 && j < 1300) return 3;
    return ((j * 37 + k * 11 + (j >> 3) * (k + 1)) >> 1) & 3;
  endfunction

  function automatic int expWord(int j);
    int s = 0;
    for (int k = 0; k < 9; k++) s += codeOf(j, k) << (8 - k);
    return (s > 1023) ? 1023 : s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic driveCycle(int c);
    for (int k = 0; k < 9; k++) stageCodes[2*k +: 2] = 2'(codeOf(c - k, k));
  endtask

  initial begin
    int cntModel;
    rst = 1'b1; stageCodes = '0; outEnN = 1'b0; powerDown = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dataWord == 10'd0, "R10 reset word", int'(dataWord), 0);
    chk(dataValid == 1'b0, "R10 R9 reset valid", int'(dataValid), 0);
    rst = 1'b0;
    driveCycle(0);
    cntModel = 0;
    for (int n = 1; n <= NCYC; n++) begin
      int j;
      bit expValid;
      bit drvOn;
      string tag;
      @(posedge clk);
      if (powerDown) cntModel = 0;
      else if (cntModel < 5) cntModel++;
      @(negedge clk);
      expValid = (cntModel == 5) && !powerDown;
      chk(dataValid == expValid, "R9 valid", int'(dataValid), int'(expValid));
      if (n >= 13) begin
        j = n - 13;
        tag = "R1 R2 R3 R6 word";
        if (j == 0 || j == 512 || j == 1023) tag = "R5 coding word";
        if (j >= 1280 && j < 1300) tag = "R4 saturate word";
        if (powerDown) tag = "R8 word during power-down";
        if (outEnN) tag = "R7 word while disabled";
        chk(int'(dataWord) == expWord(j), tag, int'(dataWord), expWord(j));
      end
      outEnN    = (n >= 300 && n < 320) || (n >= 1420 && n < 1424);
      powerDown = (n >= 1350 && n < 1360) || (n == 1400);
      driveCycle(n);
      #1;
      drvOn = !outEnN && !powerDown;
      chk(dataDrive == {10{drvOn}}, powerDown ? "R8 drive" : "R7 drive",
          int'(dataDrive), drvOn ? 1023 : 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule